// File: doc/BRIEF.md
# Normal-Basis Field Inverter for GF(2^131)

This block returns the multiplicative inverse of an element of GF(2^131) held in a type-II optimal normal basis. The caller presents the element on `elem_in` and raises `start` for one cycle. Some time later the inverse appears on `inv_out`, and `done` is high for exactly one cycle. The inverse is formed as a^(2^131 - 2) with an Itoh-Tsujii addition chain. The chain is derived from the binary digits of 130. The intermediate exponents of the form 2^k - 1 are k = 1, 2, 4, 8, 16, 32, 64, 65, 130, and a last squaring gives the inverse.

In a normal basis, raising to any power of two is a cyclic rotation of the coefficient vector. Every squaring in the chain is therefore a barrel rotation inside the operand path and costs no cycles. Seven doubling steps and one step that adds the input make eight multiplications in total. All of them run on one internal bit-serial multiplier, which produces one product coefficient per cycle and stays busy for almost the whole operation.

Top module: `nb_inverter`

## Requirements
- R1: While reset is asserted and in the first cycle after reset, `done` is 0 and `inv_out` is all zeros.
- R2: A `start` sampled high while the block is idle produces a single-cycle `done` pulse exactly 1064 clock edges later, which is eight multiplications of 133 cycles each. `done` is 0 at every edge in between.
- R3: Bit i of every vector is the coefficient of the basis element beta^(2^i). For every nonzero input, the normal-basis product of `inv_out` and the input equals the all-ones vector, which is the field's unit.
- R4: The all-ones input (the unit) returns the all-ones vector.
- R5: An all-zero input returns an all-zero result after the same latency.
- R6: A `start` that arrives while an operation is in progress is ignored. The running result is unaffected and no additional `done` pulse follows.
- R7: `inv_out` changes only at the edge that raises `done` and holds its value until the next completed operation.
- R8: Inverting a returned inverse gives back the original input.
- R9: Squaring is a rotation toward higher bit index, with bit 130 moving to bit 0. The inverse of the rotated input equals the rotated inverse of the original input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to invert `elem_in`; ignored while busy |
| elem_in | input | 131 | Element to invert, normal-basis coefficients |
| done | output | 1 | One-cycle pulse marking a new result on `inv_out` |
| inv_out | output | 131 | Inverse of the last accepted element, held between operations |

## Verification
Each result is due 1064 edges after the edge that samples `start`. The bench counts falling edges from that point. It requires `done` to be low at each of the first 1063 falling edges, high at the 1064th, and low again at the next one, and it reads `inv_out` only at the 1064th. For the ignored-start case the count runs from the first request, and the bench watches a further full latency window to confirm that no second pulse arrives. Correctness of the value is judged with a reference multiplier in the bench. That multiplier works on 263-term cyclic polynomials and is independent of the serial structure in the design.

// File: rtl/nb_inv_pkg.sv
package nb_inv_pkg;

  localparam int FIELD_M = 131;

  typedef enum logic [1:0] {
    CS_IDLE  = 2'd0,
    CS_ISSUE = 2'd1,
    CS_WAIT  = 2'd2
  } chain_st_e;

  // 2^n reduced modulo p
  function automatic int pow2_mod(input int n, input int p);
    int v;
    v = 1;
    for (int t = 0; t < n; t++) v = (v * 2) % p;
    return v;
  endfunction

  // k in [0,m) with 2^k == +e or -e (mod p); -1 when e == 0 (mod p)
  function automatic int dlog_pm(input int e, input int m, input int p);
    int v;
    int pw;
    int r;
    v  = ((e % p) + p) % p;
    pw = 1;
    r  = -1;
    if (v != 0) begin
      for (int k = 0; k < m; k++) begin
        if (r < 0 && (pw == v || pw == p - v)) r = k;
        pw = (pw * 2) % p;
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/nb_rotl.sv
// Left cyclic rotation by a variable amount (power-of-two raising in normal basis)
module nb_rotl #(
  parameter int W  = 131,
  parameter int SW = 8
) (
  input  logic [W-1:0]  din,
  input  logic [SW-1:0] amt,
  output logic [W-1:0]  dout
);

  logic [W-1:0] stg [SW+1];

  assign stg[0] = din;

  for (genvar s = 0; s < SW; s++) begin : g_stage
    localparam int R = (2 ** s) % W;
    logic [W-1:0] rot;
    if (R == 0) begin : g_id
      assign rot = stg[s];
    end else begin : g_rot
      assign rot = {stg[s][W-1-R:0], stg[s][W-1:W-R]};
    end
    assign stg[s+1] = amt[s] ? rot : stg[s];
  end

  assign dout = stg[SW];

endmodule

// File: rtl/nb_mo_mul.sv
// Bit-serial type-II normal-basis multiplier: one product coefficient per cycle
module nb_mo_mul
  import nb_inv_pkg::*;
#(
  parameter int M = FIELD_M
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [M-1:0] op_x,
  input  logic [M-1:0] op_y,
  output logic         done,
  output logic [M-1:0] prod
);

  localparam int P  = 2 * M + 1;
  localparam int CW = $clog2(M);

  logic [M-1:0]  x_q, x_n, y_q, y_n, p_q, p_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          busy_q, busy_n, done_q, done_n;
  logic          ld, stp;
  logic [M-1:0]  term;
  logic          obit;

  // coefficient of beta^(2^0) in x*y: row i pairs with j where 2^j == +-(2^i -+ 1) mod P
  for (genvar i = 0; i < M; i++) begin : g_row
    localparam int PI = pow2_mod(i, P);
    localparam int J1 = dlog_pm(PI - 1, M, P);
    localparam int J2 = dlog_pm(PI + 1, M, P);
    if (J1 >= 0 && J2 >= 0) begin : g_two
      assign term[i] = x_q[i] & (y_q[J1] ^ y_q[J2]);
    end else if (J1 >= 0) begin : g_j1
      assign term[i] = x_q[i] & y_q[J1];
    end else if (J2 >= 0) begin : g_j2
      assign term[i] = x_q[i] & y_q[J2];
    end else begin : g_none
      assign term[i] = 1'b0;
    end
  end

  assign obit = ^term;
  assign ld   = go && !busy_q;
  assign stp  = busy_q;

  always_comb begin
    x_n    = x_q;
    y_n    = y_q;
    p_n    = p_q;
    cnt_n  = cnt_q;
    busy_n = busy_q;
    done_n = 1'b0;
    if (ld) begin
      x_n    = op_x;
      y_n    = op_y;
      cnt_n  = '0;
      busy_n = 1'b1;
    end else if (stp) begin
      x_n   = {x_q[0], x_q[M-1:1]};
      y_n   = {y_q[0], y_q[M-1:1]};
      p_n   = {obit, p_q[M-1:1]};
      cnt_n = cnt_q + 1'b1;
      if (cnt_q == CW'(M - 1)) begin
        busy_n = 1'b0;
        done_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q    <= '0;
      y_q    <= '0;
      p_q    <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (ld || stp) begin
        x_q    <= x_n;
        y_q    <= y_n;
        cnt_q  <= cnt_n;
        busy_q <= busy_n;
      end
      if (stp) p_q <= p_n;
      done_q <= done_n;
    end
  end

  assign done = done_q;
  assign prod = p_q;

  // R2
  mul_go_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !busy_q);

endmodule

// File: rtl/nb_chain_ctrl.sv
// Sequencer for the addition chain over the binary digits of M-1
module nb_chain_ctrl
  import nb_inv_pkg::*;
#(
  parameter int M  = FIELD_M,
  parameter int KW = $clog2(M)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          mul_done,
  output logic          load,
  output logic          mul_go,
  output logic          op_inc,
  output logic          cap,
  output logic          fin,
  output logic          busy,
  output logic [KW-1:0] rot_amt
);

  localparam int            E      = M - 1;
  localparam int            BIW    = (KW > 2) ? $clog2(KW) : 1;
  localparam logic [KW-1:0] EXP    = KW'(E);
  localparam logic [BIW-1:0] BI_TOP = BIW'(KW - 2);

  chain_st_e      st_q, st_n;
  logic [BIW-1:0] bi_q, bi_n;
  logic           inc_q, inc_n;
  logic [KW-1:0]  k_q, k_n;
  logic           adv;

  always_comb begin
    st_n   = st_q;
    bi_n   = bi_q;
    inc_n  = inc_q;
    k_n    = k_q;
    load   = 1'b0;
    mul_go = 1'b0;
    cap    = 1'b0;
    fin    = 1'b0;
    adv    = 1'b0;
    case (st_q)
      CS_IDLE: begin
        if (start) begin
          load  = 1'b1;
          st_n  = CS_ISSUE;
          bi_n  = BI_TOP;
          inc_n = 1'b0;
          k_n   = KW'(1);
        end
      end
      CS_ISSUE: begin
        mul_go = 1'b1;
        st_n   = CS_WAIT;
      end
      CS_WAIT: begin
        if (mul_done) begin
          cap = 1'b1;
          if (!inc_q) begin
            k_n = k_q << 1;
            if (EXP[bi_q]) begin
              inc_n = 1'b1;
              st_n  = CS_ISSUE;
            end else begin
              adv = 1'b1;
            end
          end else begin
            k_n = k_q + 1'b1;
            adv = 1'b1;
          end
          if (adv) begin
            inc_n = 1'b0;
            if (bi_q == '0) begin
              fin  = 1'b1;
              st_n = CS_IDLE;
            end else begin
              bi_n = bi_q - 1'b1;
              st_n = CS_ISSUE;
            end
          end
        end
      end
      default: st_n = CS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= CS_IDLE;
      bi_q  <= '0;
      inc_q <= 1'b0;
      k_q   <= '0;
    end else begin
      st_q <= st_n;
      if (load || cap) begin
        bi_q  <= bi_n;
        inc_q <= inc_n;
        k_q   <= k_n;
      end
    end
  end

  assign op_inc  = inc_q;
  assign rot_amt = inc_q ? KW'(1) : k_q;
  assign busy    = (st_q != CS_IDLE);

  // R2
  mul_done_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mul_done |-> (st_q == CS_WAIT));

endmodule

// File: rtl/nb_inverter.sv
module nb_inverter
  import nb_inv_pkg::*;
#(
  parameter int M = FIELD_M
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [M-1:0] elem_in,
  output logic         done,
  output logic [M-1:0] inv_out
);

  localparam int KW = $clog2(M);

  logic [M-1:0]  a_q, a_n, acc_q, acc_n, res_q, res_n;
  logic          done_q;
  logic [M-1:0]  x_op, y_op, prod;
  logic [KW-1:0] rot_amt;
  logic          load, mul_go, op_inc, cap, fin, busy, mul_done;

  nb_chain_ctrl #(.M(M), .KW(KW)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .mul_done (mul_done),
    .load     (load),
    .mul_go   (mul_go),
    .op_inc   (op_inc),
    .cap      (cap),
    .fin      (fin),
    .busy     (busy),
    .rot_amt  (rot_amt)
  );

  nb_rotl #(.W(M), .SW(KW)) u_rot (
    .din  (acc_q),
    .amt  (rot_amt),
    .dout (x_op)
  );

  assign y_op = op_inc ? a_q : acc_q;

  nb_mo_mul #(.M(M)) u_mul (
    .clk   (clk),
    .rst_n (rst_n),
    .go    (mul_go),
    .op_x  (x_op),
    .op_y  (y_op),
    .done  (mul_done),
    .prod  (prod)
  );

  always_comb begin
    a_n   = load ? elem_in : a_q;
    acc_n = load ? elem_in : (cap ? prod : acc_q);
    res_n = fin ? {prod[M-2:0], prod[M-1]} : res_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q    <= '0;
      acc_q  <= '0;
      res_q  <= '0;
      done_q <= 1'b0;
    end else begin
      if (load) a_q <= a_n;
      if (load || cap) acc_q <= acc_n;
      if (fin) res_q <= res_n;
      done_q <= fin;
    end
  end

  assign done    = done_q;
  assign inv_out = res_q;

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R6
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(a_q));

  // R5
  zero_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> ((res_q == '0) == (a_q == '0)));

  // R7
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(res_q) |-> done_q);

endmodule

// File: tb/test_nb_inverter.sv
module test_nb_inverter;

  localparam int M   = 131;
  localparam int P   = 2 * M + 1;
  localparam int LAT = 1064;

  logic         clk;
  logic         rst_n;
  logic         start;
  logic [M-1:0] elem_in;
  logic         done;
  logic [M-1:0] inv_out;

  int checks;
  int errors;

  nb_inverter #(.M(M)) i_nb_inverter (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .elem_in (elem_in),
    .done    (done),
    .inv_out (inv_out)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [M-1:0] all_ones();
    return '1;
  endfunction

  function automatic logic [M-1:0] sq(input logic [M-1:0] v);
    return {v[M-2:0], v[M-1]};
  endfunction

  // reference product through the cyclic ring GF(2)[g]/(g^P - 1)
  function automatic logic [M-1:0] ref_mul(input logic [M-1:0] a, input logic [M-1:0] b);
    logic [P-1:0] fa, fb, pr;
    logic [M-1:0] r;
    int e;
    fa = '0;
    fb = '0;
    pr = '0;
    e  = 1;
    for (int i = 0; i < M; i++) begin
      if (a[i]) begin fa[e] = ~fa[e]; fa[P-e] = ~fa[P-e]; end
      if (b[i]) begin fb[e] = ~fb[e]; fb[P-e] = ~fb[P-e]; end
      e = (2 * e) % P;
    end
    for (int u = 0; u < P; u++)
      if (fa[u])
        for (int v = 0; v < P; v++)
          if (fb[v]) pr[(u + v) % P] = ~pr[(u + v) % P];
    e = 1;
    for (int i = 0; i < M; i++) begin
      r[i] = pr[e];
      e = (2 * e) % P;
    end
    return r;
  endfunction

  function automatic logic [M-1:0] rnd_elem();
    logic [M-1:0] v;
    v = '0;
    for (int w = 0; w < 5; w++) v = {v[M-33:0], 32'($urandom)};
    if (v == '0) v[0] = 1'b1;
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [M-1:0] act, input logic [M-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // launches one inversion and checks timing (R2); returns the result
  task automatic run_inv(input logic [M-1:0] a, output logic [M-1:0] r);
    int early;
    early = 0;
    @(negedge clk);
    elem_in = a;
    start   = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int j = 1; j < LAT; j++) begin
      @(negedge clk);
      if (done) early++;
    end
    check(early == 0, "R2", "done before latency", M'(early), '0);
    @(negedge clk);
    check(done == 1'b1, "R2", "done at latency", M'(done), M'(1));
    r = inv_out;
    @(negedge clk);
    check(done == 1'b0, "R2", "done single cycle", M'(done), '0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R2 watchdog: actual 200000 cycles expected completion earlier");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [M-1:0] a, r, r2, a0, a1, held;
    int extra;
    checks  = 0;
    errors  = 0;
    rst_n   = 1'b0;
    start   = 1'b0;
    elem_in = '0;
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    // R1
    check(done == 1'b0, "R1", "done in reset", M'(done), '0);
    check(inv_out == '0, "R1", "result in reset", inv_out, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check(done == 1'b0 && inv_out == '0, "R1", "after reset", inv_out, '0);

    // R4 unit maps to unit
    run_inv(all_ones(), r);
    check(r == all_ones(), "R4", "inverse of unit", r, all_ones());

    // R5 zero maps to zero
    run_inv('0, r);
    check(r == '0, "R5", "inverse of zero", r, '0);

    // R3 single-coefficient inputs
    a = '0; a[0] = 1'b1;
    run_inv(a, r);
    check(ref_mul(a, r) == all_ones(), "R3", "low single bit", ref_mul(a, r), all_ones());
    a = '0; a[M-1] = 1'b1;
    run_inv(a, r);
    check(ref_mul(a, r) == all_ones(), "R3", "high single bit", ref_mul(a, r), all_ones());

    // R3 random elements, R8 on the first few
    for (int n = 0; n < 14; n++) begin
      a = rnd_elem();
      run_inv(a, r);
      check(ref_mul(a, r) == all_ones(), "R3", "random product", ref_mul(a, r), all_ones());
      if (n < 3) begin
        run_inv(r, r2);
        check(r2 == a, "R8", "double inverse", r2, a);
      end
    end

    // R9 rotation commutes with inversion
    a = rnd_elem();
    run_inv(a, r);
    run_inv(sq(a), r2);
    check(r2 == sq(r), "R9", "inverse of square", r2, sq(r));

    // R7 result held while idle
    held = inv_out;
    repeat (40) @(negedge clk);
    check(inv_out == held && done == 1'b0, "R7", "idle hold", inv_out, held);

    // R6 start during busy ignored
    a0 = rnd_elem();
    a1 = rnd_elem();
    extra = 0;
    @(negedge clk);
    elem_in = a0;
    start   = 1'b1;
    @(negedge clk);
    start = 1'b0;
    r = '0;
    for (int j = 1; j <= 2 * LAT + 4; j++) begin
      if (j == 299) begin elem_in = a1; start = 1'b1; end
      if (j == 300) start = 1'b0;
      @(negedge clk);
      if (j == LAT) begin
        check(done == 1'b1, "R6", "done for first request", M'(done), M'(1));
        r = inv_out;
      end else if (done) begin
        extra++;
      end
    end
    check(extra == 0, "R6", "extra done pulses", M'(extra), '0);
    check(ref_mul(a0, r) == all_ones(), "R6", "result of first request",
          ref_mul(a0, r), all_ones());
    check(inv_out == r, "R7", "hold after ignored start", inv_out, r);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule